// File: doc/BRIEF.md
# Guarded Fixed-Point Arithmetic Unit

This block performs arithmetic on 32-bit signed fixed-point words. The word has 10 fraction bits and 20 integer bits. Above them sit an overflow guard bit (bit 30) and the sign bit (bit 31). A word is in range only when the guard bit matches the sign bit. The block runs seven two's-complement operations, plus a pass-through of the first operand. For every result it reports whether the exact value rose above the largest in-range word (overflow) or fell below the smallest (underflow). When either flag is set, the caller rescales the operands and repeats the request.

The caller presents `op`, `opa` and `opb` together with a one-cycle `start` while `busy` is low. Add, subtract, increment, decrement and pass-through finish in one cycle. Multiply takes two cycles. Divide and modulus run a restoring divider that produces one quotient bit per cycle.

A sequencer with five states controls the work:
- `ST_IDLE` goes to `ST_MULT` on a multiply start.
- `ST_IDLE` goes to `ST_DIVIDE` on a divide or modulus start whose divisor is nonzero.
- `ST_IDLE` goes to `ST_DONE` on any other start, including a divide or modulus by zero.
- `ST_MULT` goes to `ST_DONE`.
- `ST_DIVIDE` stays in place until the last quotient bit is done, then goes to `ST_FIXUP`.
- `ST_FIXUP` applies the sign, then goes to `ST_DONE`.
- `ST_DONE` raises `done` for one cycle, then returns to `ST_IDLE`.

Top module: `fxp_alu`

## Requirements
- R1: A result delivered with both flags clear always has bit 30 equal to bit 31.
- R2: Opcodes ADD=0 and SUB=1 return opa+opb and opa-opb, treating both operands as signed 32-bit integers.
- R3: Opcodes INC=5 and DEC=6 return opa+0x400 and opa-0x400, that is, plus or minus exactly 1.0. opb is ignored.
- R4: If the exact result is above 0x3FFFFFFF, ovf=1. If it is below the signed value -0x40000000 (word 0xC0000000), unf=1. In both cases the result carries the low 32 bits of the exact value. ovf and unf are never high together.
- R5: Opcode MUL=2 forms the full signed 64-bit product of opa and opb, then shifts it right arithmetically by 10 (rounding toward minus infinity). The range check of R4 applies to that shifted value.
- R6: Opcode DIV=3 returns (opa*1024)/opb, truncated toward zero, with the R4 range check.
- R7: Opcode MOD=4 returns the remainder of the signed division opa/opb, truncated toward zero. The remainder takes the sign of opa.
- R8: DIV or MOD with opb=0 gives result 0, ovf=1 and unf=0, with `done` one cycle after the start.
- R9: `done` is high for exactly one cycle. Counting rising edges from the edge that accepts `start`, `done` is seen after 1 edge for ADD, SUB, INC, DEC and PASS, after 2 edges for MUL, and after 44 edges for DIV and MOD with a nonzero divisor. `busy` stays high from acceptance through the `done` cycle.
- R10: A `start` that arrives while `busy` is high is ignored. result, ovf and unf hold their values until the next completion.
- R11: After reset, result is 0 and done, busy, ovf and unf are all 0.
- R12: Opcode PASS=7 returns opa unchanged and applies the R4 range check to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when busy is low |
| op | input | 3 | Operation code (see R2 to R12) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Result word |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A request is in progress |
| ovf | output | 1 | Result is above the in-range maximum |
| unf | output | 1 | Result is below the in-range minimum |

## Verification
The hardest results to reach from the ports are the divider's edge cases. One is a quotient with a magnitude far above 32 bits. Another is a dividend of 0x80000000, whose magnitude does not fit a positive 32-bit word. A third is a remainder that has to take the dividend's sign. The bench crosses sixteen hand-picked words against each other under every opcode. The words include both range limits, 0x80000000, the out-of-range 0x40000000, plus and minus one least significant bit, and the fixed-point units, so the sweep reaches these cases directly. It also pulses `start` several times in the middle of a division, which shows at the outputs that the running request is not disturbed.

// File: rtl/fxp_pkg.sv
package fxp_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_MOD  = 3'd4,
        OP_INC  = 3'd5,
        OP_DEC  = 3'd6,
        OP_PASS = 3'd7
    } fxp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MULT,
        ST_DIVIDE,
        ST_FIXUP,
        ST_DONE
    } fxp_state_e;

endpackage

// File: rtl/fxp_addsub.sv
module fxp_addsub
    import fxp_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FRAC  = 10
) (
    input  logic [WIDTH-1:0]     a,
    input  logic [WIDTH-1:0]     b,
    input  fxp_op_e              op,
    output logic signed [2*WIDTH-1:0] value
);
    localparam int EW = 2 * WIDTH;
    localparam logic [EW-1:0] UNIT = EW'(1) << FRAC;

    logic signed [EW-1:0] a_ext;
    logic signed [EW-1:0] b_ext;
    logic signed [EW-1:0] rhs;

    always_comb begin
        a_ext = $signed({{(EW-WIDTH){a[WIDTH-1]}}, a});
        b_ext = $signed({{(EW-WIDTH){b[WIDTH-1]}}, b});
        unique case (op)
            OP_SUB:  rhs = -b_ext;
            OP_INC:  rhs = $signed(UNIT);
            OP_DEC:  rhs = -$signed(UNIT);
            OP_PASS: rhs = '0;
            default: rhs = b_ext;
        endcase
        value = a_ext + rhs;
    end

endmodule

// File: rtl/fxp_mul.sv
module fxp_mul #(
    parameter int WIDTH = 32,
    parameter int FRAC  = 10
) (
    input  logic [WIDTH-1:0]          a,
    input  logic [WIDTH-1:0]          b,
    output logic signed [2*WIDTH-1:0] value
);
    localparam int EW = 2 * WIDTH;

    logic signed [EW-1:0] prod;

    always_comb begin
        prod  = $signed({{WIDTH{a[WIDTH-1]}}, a}) * $signed({{WIDTH{b[WIDTH-1]}}, b});
        value = prod >>> FRAC;
    end

endmodule

// File: rtl/fxp_divcore.sv
module fxp_divcore #(
    parameter int WIDTH = 32,
    parameter int FRAC  = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic                   step,
    input  logic                   pre_shift,
    input  logic [WIDTH-1:0]       dvd,
    input  logic [WIDTH-1:0]       dvs,
    output logic [WIDTH+FRAC-1:0]  quo,
    output logic [WIDTH-1:0]       rem,
    output logic                   last
);
    localparam int DW = WIDTH + FRAC;
    localparam int CW = $clog2(DW);

    logic [DW-1:0]    d_q;
    logic [WIDTH-1:0] r_q;
    logic [WIDTH-1:0] v_q;
    logic [CW-1:0]    cnt_q;

    logic [WIDTH:0]   trial;
    logic [WIDTH:0]   diff;
    logic             take;

    always_comb begin
        trial = {r_q, d_q[DW-1]};
        diff  = trial - {1'b0, v_q};
        take  = trial >= {1'b0, v_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q   <= '0;
            r_q   <= '0;
            v_q   <= '0;
            cnt_q <= '0;
        end else if (load) begin
            d_q   <= pre_shift ? {dvd, {FRAC{1'b0}}} : {{FRAC{1'b0}}, dvd};
            r_q   <= '0;
            v_q   <= dvs;
            cnt_q <= CW'(DW - 1);
        end else if (step) begin
            d_q   <= {d_q[DW-2:0], take};
            r_q   <= take ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign quo  = d_q;
    assign rem  = r_q;
    assign last = (cnt_q == '0);

    // R7: the partial remainder stays below the divisor after every step
    p_rem_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q != '0) |-> (r_q < v_q));

    // R9: the sequencer never loads and steps in the same cycle
    p_no_load_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/fxp_alu.sv
module fxp_alu
    import fxp_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FRAC  = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             busy,
    output logic             ovf,
    output logic             unf
);
    localparam int EW = 2 * WIDTH;
    localparam int DW = WIDTH + FRAC;
    localparam logic signed [EW-1:0] LIM   = $signed(EW'(1) << (WIDTH - 2));
    localparam logic signed [EW-1:0] MAX_V = LIM - 1;
    localparam logic signed [EW-1:0] MIN_V = -LIM;

    function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] x);
        return x[WIDTH-1] ? (~x + 1'b1) : x;
    endfunction

    fxp_state_e state_q, state_d;
    fxp_op_e    op_e, op_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic             neg_q;

    logic accept, is_div_op, b_zero, div_zero;
    logic div_load, div_step, div_last, capture;

    logic signed [EW-1:0] as_val, mul_val, div_val, sel_val;
    logic [EW-1:0]        div_mag;
    logic [DW-1:0]        quo;
    logic [WIDTH-1:0]     rem;
    logic                 ovf_n, unf_n;

    assign op_e      = fxp_op_e'(op);
    assign is_div_op = (op_e == OP_DIV) || (op_e == OP_MOD);
    assign b_zero    = (opb == '0);
    assign accept    = (state_q == ST_IDLE) && start;
    assign div_zero  = accept && is_div_op && b_zero;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (op_e == OP_MUL)           state_d = ST_MULT;
                    else if (is_div_op && !b_zero) state_d = ST_DIVIDE;
                    else                          state_d = ST_DONE;
                end
            end
            ST_MULT:   state_d = ST_DONE;
            ST_DIVIDE: if (div_last) state_d = ST_FIXUP;
            ST_FIXUP:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- state-decoded outputs ----------------
    always_comb begin
        done     = 1'b0;
        busy     = 1'b1;
        div_load = 1'b0;
        div_step = 1'b0;
        capture  = 1'b0;
        sel_val  = as_val;
        unique case (state_q)
            ST_IDLE: begin
                busy     = 1'b0;
                div_load = start && is_div_op && !b_zero;
                capture  = start && (op_e != OP_MUL) && !(is_div_op && !b_zero);
                sel_val  = as_val;
            end
            ST_MULT: begin
                capture = 1'b1;
                sel_val = mul_val;
            end
            ST_DIVIDE: div_step = 1'b1;
            ST_FIXUP: begin
                capture = 1'b1;
                sel_val = div_val;
            end
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // ---------------- arithmetic units ----------------
    fxp_addsub #(.WIDTH(WIDTH), .FRAC(FRAC)) u_addsub (
        .a     (opa),
        .b     (opb),
        .op    (op_e),
        .value (as_val)
    );

    fxp_mul #(.WIDTH(WIDTH), .FRAC(FRAC)) u_mul (
        .a     (a_q),
        .b     (b_q),
        .value (mul_val)
    );

    fxp_divcore #(.WIDTH(WIDTH), .FRAC(FRAC)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (div_load),
        .step      (div_step),
        .pre_shift (op_e == OP_DIV),
        .dvd       (mag(opa)),
        .dvs       (mag(opb)),
        .quo       (quo),
        .rem       (rem),
        .last      (div_last)
    );

    always_comb begin
        div_mag = (op_q == OP_MOD) ? EW'(rem) : EW'(quo);
        div_val = neg_q ? -$signed(div_mag) : $signed(div_mag);
        ovf_n   = sel_val > MAX_V;
        unf_n   = sel_val < MIN_V;
    end

    // ---------------- operand and result registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_ADD;
            a_q    <= '0;
            b_q    <= '0;
            neg_q  <= 1'b0;
            result <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (accept) begin
                op_q  <= op_e;
                a_q   <= opa;
                b_q   <= opb;
                neg_q <= (op_e == OP_MOD) ? opa[WIDTH-1] : (opa[WIDTH-1] ^ opb[WIDTH-1]);
            end
            if (div_zero) begin
                result <= '0;
                ovf    <= 1'b1;
                unf    <= 1'b0;
            end else if (capture) begin
                result <= sel_val[WIDTH-1:0];
                ovf    <= ovf_n;
                unf    <= unf_n;
            end
        end
    end

    // ---------------- assertions ----------------
    p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf && unf));

    p_valid_form_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf && !unf) |-> (result[WIDTH-1] == result[WIDTH-2]));

    p_div_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && start && ((op == 3'd3) || (op == 3'd4)) && (opb == '0))
        |=> (done && ovf && !unf && (result == '0)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(result) && $stable(ovf) && $stable(unf)));

endmodule

// File: tb/sim_fxp_alu.sv
`timescale 1ns/1ps
module sim_fxp_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] result;
    logic        done, busy, ovf, unf;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    fxp_alu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .result(result), .done(done), .busy(busy), .ovf(ovf), .unf(unf)
    );

    function automatic logic [31:0] pick(input int i);
        case (i)
            0:  return 32'h00000000;
            1:  return 32'h00000400;
            2:  return 32'hFFFFFC00;
            3:  return 32'h3FFFFFFF;
            4:  return 32'hC0000000;
            5:  return 32'h00000001;
            6:  return 32'hFFFFFFFF;
            7:  return 32'h00000A00;
            8:  return 32'hFFFFF600;
            9:  return 32'h00100000;
            10: return 32'hFFF00000;
            11: return 32'h2AAAAAAA;
            12: return 32'h40000000;
            13: return 32'h80000000;
            14: return 32'h000003FF;
            default: return 32'h12345678;
        endcase
    endfunction

    task automatic report(input string tag, input string what,
                          input logic [63:0] act, input logic [63:0] exp);
        miscompares++;
        $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    endtask

    task automatic run_op(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        logic signed [63:0] sa, sb, v;
        logic [31:0] e_res;
        logic e_ovf, e_unf;
        int e_lat, lat;
        string tag;
        sa = $signed({{32{a[31]}}, a});
        sb = $signed({{32{b[31]}}, b});
        e_lat = 1;
        v = 0;
        case (o)
            3'd0: begin v = sa + sb;         tag = "R2"; end
            3'd1: begin v = sa - sb;         tag = "R2"; end
            3'd2: begin v = (sa * sb) >>> 10; tag = "R5"; e_lat = 2; end
            3'd3: begin tag = "R6"; if (b != 0) begin v = (sa * 1024) / sb; e_lat = 44; end end
            3'd4: begin tag = "R7"; if (b != 0) begin v = sa % sb; e_lat = 44; end end
            3'd5: begin v = sa + 1024;       tag = "R3"; end
            3'd6: begin v = sa - 1024;       tag = "R3"; end
            default: begin v = sa;           tag = "R12"; end
        endcase
        if ((o == 3'd3 || o == 3'd4) && b == 0) begin
            tag = "R8"; e_res = 0; e_ovf = 1'b1; e_unf = 1'b0;
        end else begin
            e_res = v[31:0];
            e_ovf = v > 64'sh3FFFFFFF;
            e_unf = v < -64'sh40000000;
        end
        @(negedge clk);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        opb = ~b;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        vectors++;
        if (lat != e_lat)
            report("R9", $sformatf("latency op%0d", o), 64'(lat), 64'(e_lat));
        else if (result !== e_res)
            report(tag, $sformatf("result op%0d a=%h b=%h", o, a, b), 64'(result), 64'(e_res));
        else if (ovf !== e_ovf || unf !== e_unf)
            report("R4", $sformatf("flags op%0d a=%h b=%h", o, a, b), {62'b0, ovf, unf}, {62'b0, e_ovf, e_unf});
        // R1: a clean result keeps guard equal to sign
        vectors++;
        if (!ovf && !unf && result[31] != result[30])
            report("R1", "guard vs sign", 64'(result), 64'(e_res));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        vectors++;
        if (result !== 0 || done || busy || ovf || unf)
            report("R11", "reset state", {result, 27'b0, done, busy, ovf, unf, 1'b0}, 64'd0);

        // Sweep every opcode over all operand pairs
        for (int o = 0; o < 8; o++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    run_op(3'(o), pick(i), pick(j));

        // R10: starts while busy are ignored; result holds afterwards
        @(negedge clk);
        start = 1'b1; op = 3'd3; opa = 32'h00002800; opb = 32'h00000800;
        @(negedge clk);
        start = 1'b0;
        begin
            int lat;
            lat = 1;
            while (!done && lat < 100) begin
                @(negedge clk);
                lat++;
                start = (lat % 7 == 0);
                op = 3'd0; opa = 32'h1; opb = 32'h1;
                if (done) start = 1'b0;
            end
            start = 1'b0;
            vectors++;
            if (lat != 44 || result !== 32'h00001400)
                report("R10", "busy start disturbed divide", {32'(lat), result}, {32'd44, 32'h1400});
        end
        repeat (5) begin
            @(negedge clk);
            opa = 32'h7;
            vectors++;
            if (done || result !== 32'h00001400)
                report("R10", "result hold", {31'b0, done, result}, 64'h1400);
        end
        // R9: busy clears once done has passed
        vectors++;
        if (busy) report("R9", "busy after done", 64'(busy), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule